// File: doc/BRIEF.md
# Peak-Current PWM Control Core

This block is a clocked digital model of a fixed-frequency, peak-current-mode pulse-width modulator. A timing counter splits every oscillator period into a charge interval and a discharge interval, whose lengths come from two input codes. At the start of an oscillator period the gate-drive bit turns on. It turns off when the sampled current-sense code reaches a trip level. That trip level is computed from the error-amplifier (compensation) code and limited to a fixed maximum, which limits the current on every cycle.

A toggle stage lets only every other oscillator period drive, so the gate switches at half the oscillator rate. A latch stops a pulse from turning on again in the same period once it has ended. Two hysteretic undervoltage monitors hold the gate low until the block is ready: one watches the supply code and the other watches the reference code. All analog quantities arrive as unsigned millivolt codes from external converters.

Top module: `pwmc_top`

## Requirements
- R1: One oscillator period lasts `chg_len_i + dis_len_i` clocks (charge interval first, each length at least 1). `disch_o` is high during the discharge clocks, and `gate_o` is never high during them.
- R2: Only even-numbered periods may drive, counting from 0 at the first period after lockout ends. `skip_o` is high during odd periods, and the first period after lockout always drives.
- R3: In a driving period, `gate_o` is high from the first charge clock. In any clock where `cs_code_i` is at or above the trip level, it is low in that same clock.
- R4: Once a pulse has ended in a period, `gate_o` stays low for the rest of that period, even if `cs_code_i` falls back below the trip level.
- R5: The trip level is floor((comp − 1400)/3) mV, limited to at most 1000 mV.
- R6: When `comp_code_i` ≤ 1400, the trip level is 0 and `gate_o` stays low.
- R7: `vcc_ok_o` rises one clock after the supply code is at or above the on level. It falls one clock after the code is below the off level, and otherwise holds. With `low_sel_i`=0 the levels are 16000/10000; with `low_sel_i`=1 they are 8400/7600.
- R8: `ref_ok_o` behaves the same way with levels 3600 on and 3400 off, independently of the supply monitor.
- R9: While either monitor is not ok, `gate_o` is low, the timing counter is held at the start of a charge interval, and the toggle and latch are cleared.
- R10: While `rst` is high, both monitors report lockout and `gate_o` is low, whatever the input codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_code_i | input | 16 | Supply voltage, mV |
| ref_code_i | input | 16 | Reference voltage, mV |
| comp_code_i | input | 16 | Error-amplifier output, mV |
| cs_code_i | input | 16 | Current-sense voltage, mV |
| low_sel_i | input | 1 | Supply level pair: 0 = 16000/10000, 1 = 8400/7600 |
| chg_len_i | input | 8 | Charge interval length in clocks (0 is treated as 1) |
| dis_len_i | input | 8 | Discharge interval length in clocks (0 is treated as 1) |
| gate_o | output | 1 | Gate-drive enable |
| vcc_ok_o | output | 1 | Supply monitor out of lockout |
| ref_ok_o | output | 1 | Reference monitor out of lockout |
| disch_o | output | 1 | Timing counter in discharge interval |
| skip_o | output | 1 | Current period is blanked by the toggle |

## Verification
The hardest case to reach from the ports is the latch holding the gate off after a brief over-current event in the same period. The stimulus drives a single-clock current spike in the middle of a charge interval and then returns the sense code to zero, so any re-arming of the gate would show up. Each sweep first forces lockout and then releases it, so the bench knows the period phase and parity exactly. The expected gate is then derived arithmetically, clock by clock, from the interval lengths, the trip formula and the current pattern.

// File: rtl/pwmc_pkg.sv
`timescale 1ns/1ps
package pwmc_pkg;
    localparam int CODE_W      = 16;
    localparam int LEN_W       = 8;
    localparam int COMP_OFS_MV = 1400;
    localparam int TRIP_DIV    = 3;
    localparam int TRIP_MAX_MV = 1000;
    localparam int VCC_HI_ON   = 16000;
    localparam int VCC_HI_OFF  = 10000;
    localparam int VCC_LO_ON   = 8400;
    localparam int VCC_LO_OFF  = 7600;
    localparam int REF_ON      = 3600;
    localparam int REF_OFF     = 3400;

    typedef logic [CODE_W-1:0] code_t;
    typedef enum logic { PH_CHARGE = 1'b0, PH_DISCH = 1'b1 } phase_t;

    typedef struct packed {
        logic vcc_ok;
        logic ref_ok;
    } lock_t;

    typedef struct packed {
        logic start;
        logic last;
        logic disch;
    } tick_t;

    // trip level: (comp - offset)/divider, floored at zero, limited to max
    function automatic code_t trip_level(input code_t comp);
        code_t diff;
        if (comp <= code_t'(COMP_OFS_MV))
            return '0;
        diff = (comp - code_t'(COMP_OFS_MV)) / code_t'(TRIP_DIV);
        if (diff > code_t'(TRIP_MAX_MV))
            return code_t'(TRIP_MAX_MV);
        return diff;
    endfunction
endpackage

// File: rtl/pwmc_uvmon.sv
`timescale 1ns/1ps
module pwmc_uvmon
    import pwmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_i,
    input  code_t on_i,
    input  code_t off_i,
    output logic  ok_o
);
    always_ff @(posedge clk) begin
        if (rst)
            ok_o <= 1'b0;
        else if (!ok_o && code_i >= on_i)
            ok_o <= 1'b1;
        else if (ok_o && code_i < off_i)
            ok_o <= 1'b0;
    end

    // R7 and R8: leaving lockout needs the on level, entering needs below off
    assert_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_o) |-> $past(code_i) >= $past(on_i));
    assert_off_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ok_o) |-> $past(code_i) < $past(off_i));
endmodule

// File: rtl/pwmc_ramp.sv
`timescale 1ns/1ps
module pwmc_ramp
    import pwmc_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic [LW-1:0] chg_len_i,
    input  logic [LW-1:0] dis_len_i,
    output tick_t         tick_o
);
    logic [LW-1:0] cnt_q;
    phase_t        ph_q;
    logic [LW-1:0] chg_eff, dis_eff, lim;
    logic          last;

    always_comb begin
        chg_eff = (chg_len_i == '0) ? LW'(1) : chg_len_i;
        dis_eff = (dis_len_i == '0) ? LW'(1) : dis_len_i;
        lim     = (ph_q == PH_CHARGE) ? chg_eff : dis_eff;
        last    = (cnt_q == lim - LW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
            ph_q  <= PH_CHARGE;
        end else if (last) begin
            cnt_q <= '0;
            ph_q  <= (ph_q == PH_CHARGE) ? PH_DISCH : PH_CHARGE;
        end else begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    always_comb begin
        tick_o.start = run_i && (ph_q == PH_CHARGE) && (cnt_q == '0);
        tick_o.last  = run_i && (ph_q == PH_DISCH) && last;
        tick_o.disch = (ph_q == PH_DISCH);
    end

    // R9: lockout parks the counter at the start of a charge interval
    assert_park_R9: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0 && ph_q == PH_CHARGE));
endmodule

// File: rtl/pwmc_mod.sv
`timescale 1ns/1ps
module pwmc_mod
    import pwmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    input  tick_t tick_i,
    input  code_t comp_i,
    input  code_t cs_i,
    output logic  gate_o,
    output logic  skip_o
);
    code_t thr;
    logic  trip;
    logic  par_q;
    logic  cut_q;

    always_comb begin
        thr  = trip_level(comp_i);
        trip = (cs_i >= thr);
    end

    // toggle stage: parity of the oscillator period
    always_ff @(posedge clk) begin
        if (rst || !run_i)
            par_q <= 1'b0;
        else if (tick_i.last)
            par_q <= ~par_q;
    end

    // pulse latch: once tripped, held until the next period starts
    always_ff @(posedge clk) begin
        if (rst || !run_i)
            cut_q <= 1'b0;
        else if (tick_i.start)
            cut_q <= trip;
        else
            cut_q <= cut_q | trip;
    end

    always_comb begin
        gate_o = run_i && !tick_i.disch && !par_q && !trip
                 && (tick_i.start || !cut_q);
        skip_o = par_q;
    end

    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> tick_i.start);
    assert_dead_time_R1: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> !tick_i.disch);
    assert_low_comp_R6: assert property (@(posedge clk) disable iff (rst)
        (comp_i <= code_t'(COMP_OFS_MV)) |-> !gate_o);
    assert_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        gate_o |-> (cs_i < code_t'(TRIP_MAX_MV)));
    assert_odd_blank_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i.last && !par_q) |=> !gate_o);
endmodule

// File: rtl/pwmc_top.sv
`timescale 1ns/1ps
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   vcc_code_i,
    input  logic [15:0]   ref_code_i,
    input  logic [15:0]   comp_code_i,
    input  logic [15:0]   cs_code_i,
    input  logic          low_sel_i,
    input  logic [LW-1:0] chg_len_i,
    input  logic [LW-1:0] dis_len_i,
    output logic          gate_o,
    output logic          vcc_ok_o,
    output logic          ref_ok_o,
    output logic          disch_o,
    output logic          skip_o
);
    lock_t lk;
    tick_t tk;
    code_t vcc_on, vcc_off;
    logic  run;

    always_comb begin
        vcc_on  = low_sel_i ? code_t'(VCC_LO_ON)  : code_t'(VCC_HI_ON);
        vcc_off = low_sel_i ? code_t'(VCC_LO_OFF) : code_t'(VCC_HI_OFF);
        run     = lk.vcc_ok && lk.ref_ok;
    end

    pwmc_uvmon u_vcc (
        .clk(clk), .rst(rst), .code_i(vcc_code_i),
        .on_i(vcc_on), .off_i(vcc_off), .ok_o(lk.vcc_ok)
    );

    pwmc_uvmon u_ref (
        .clk(clk), .rst(rst), .code_i(ref_code_i),
        .on_i(code_t'(REF_ON)), .off_i(code_t'(REF_OFF)), .ok_o(lk.ref_ok)
    );

    pwmc_ramp #(.LW(LW)) u_ramp (
        .clk(clk), .rst(rst), .run_i(run),
        .chg_len_i(chg_len_i), .dis_len_i(dis_len_i), .tick_o(tk)
    );

    pwmc_mod u_mod (
        .clk(clk), .rst(rst), .run_i(run), .tick_i(tk),
        .comp_i(comp_code_i), .cs_i(cs_code_i),
        .gate_o(gate_o), .skip_o(skip_o)
    );

    always_comb begin
        vcc_ok_o = lk.vcc_ok;
        ref_ok_o = lk.ref_ok;
        disch_o  = tk.disch;
    end

    assert_lockout_low_R9: assert property (@(posedge clk) disable iff (rst)
        !(vcc_ok_o && ref_ok_o) |-> !gate_o);
    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (!vcc_ok_o && !ref_ok_o && !gate_o));
endmodule

// File: tb/sim_pwmc_top.sv
`timescale 1ns/1ps
module sim_pwmc_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] vcc = 16'd0, vref = 16'd0, comp = 16'd0, cs = 16'd0;
    logic        lsel = 1'b0;
    logic [7:0]  clen = 8'd4, dlen = 8'd2;
    logic        gate, vok, rok, dis, skp;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    pwmc_top u0 (
        .clk(clk), .rst(rst), .vcc_code_i(vcc), .ref_code_i(vref),
        .comp_code_i(comp), .cs_code_i(cs), .low_sel_i(lsel),
        .chg_len_i(clen), .dis_len_i(dlen), .gate_o(gate),
        .vcc_ok_o(vok), .ref_ok_o(rok), .disch_o(dis), .skip_o(skp)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int thr_of(input int c);
        int t;
        if (c <= 1400) return 0;
        t = (c - 1400) / 3;
        return (t > 1000) ? 1000 : t;
    endfunction

    // kind 0: ramp arg*pos, 1: single spike at pos arg, 2: constant arg
    function automatic int cs_of(input int kind, input int arg, input int pos);
        if (kind == 0) return arg * pos;
        if (kind == 1) return (pos == arg) ? 5000 : 0;
        return arg;
    endfunction

    function automatic logic exp_gate(input int c, input int d, input int cmp,
                                      input int kind, input int arg, input int n);
        int p, k, pos, t;
        p = c + d; k = n / p; pos = n % p; t = thr_of(cmp);
        if ((k % 2) != 0 || pos >= c) return 1'b0;
        for (int j = 0; j <= pos; j++)
            if (cs_of(kind, arg, j) >= t) return 1'b0;
        return 1'b1;
    endfunction

    task automatic window(input int c, input int d, input int cmp,
                          input int kind, input int arg, input string tag);
        int p;
        p = c + d;
        @(posedge clk); #1;
        vcc = 16'd0; cs = 16'd0; clen = 8'(c); dlen = 8'(d); comp = 16'(cmp);
        @(posedge clk); @(posedge clk); #1;
        vcc = 16'd20000;
        for (int n = 0; n < 4 * p; n++) begin
            @(posedge clk); #1;
            cs = 16'(cs_of(kind, arg, n % p));
            @(negedge clk);
            chk(tag, gate, exp_gate(c, d, cmp, kind, arg, n));
            chk("R1 disch", dis, ((n % p) >= c));
            chk("R2 skip", skp, ((n / p) % 2) != 0);
        end
    endtask

    task automatic codes(input int v, input int r, input logic ev, input logic er,
                         input string tag);
        @(posedge clk); #1;
        vcc = 16'(v); vref = 16'(r);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " vcc"}, vok, ev);
        chk({tag, " ref"}, rok, er);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: reset holds lockout despite good codes
        vcc = 16'd20000; vref = 16'd5000; comp = 16'd3000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 gate", gate, 1'b0);
        chk("R10 vcc", vok, 1'b0);
        chk("R10 ref", rok, 1'b0);
        @(posedge clk); #1;
        vcc = 16'd0; rst = 1'b0;

        // R1, R2: full pulses bounded by the charge interval
        window(6, 2, 3400, 0, 100, "R1");
        // R3: ramp crosses trip level 400 at pos 8
        window(10, 3, 2600, 0, 50, "R3");
        // R2: shortest period
        window(1, 1, 3400, 2, 0, "R2");
        // R4: spike at pos 3, then the sense code returns to zero
        window(8, 2, 3400, 1, 3, "R4");
        // R5: exact formula at level 1, and the limit at 1000
        window(5, 2, 1403, 2, 0, "R5 thr1 pass");
        window(5, 2, 1403, 2, 1, "R5 thr1 trip");
        window(5, 2, 5000, 2, 999, "R5 clamp pass");
        window(5, 2, 5000, 2, 1000, "R5 clamp trip");
        // R6: compensation at or below offset
        window(5, 2, 1402, 2, 0, "R6 1402");
        window(5, 2, 1400, 2, 0, "R6 1400");

        // R7: high level pair
        lsel = 1'b0; comp = 16'd3400; cs = 16'd0; clen = 8'd3; dlen = 8'd1;
        codes(20000, 5000, 1'b1, 1'b1, "R7 on");
        codes(12000, 5000, 1'b1, 1'b1, "R7 hold");
        codes(10000, 5000, 1'b1, 1'b1, "R7 at off");
        codes(9999, 5000, 1'b0, 1'b1, "R7 off");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 gate in lockout", gate, 1'b0);
        end
        codes(15999, 5000, 1'b0, 1'b1, "R7 below on");
        codes(16000, 5000, 1'b1, 1'b1, "R7 at on");
        // R7: low level pair
        lsel = 1'b1;
        codes(0, 5000, 1'b0, 1'b1, "R7 low drop");
        codes(8399, 5000, 1'b0, 1'b1, "R7 low below on");
        codes(8400, 5000, 1'b1, 1'b1, "R7 low on");
        codes(7600, 5000, 1'b1, 1'b1, "R7 low at off");
        codes(7599, 5000, 1'b0, 1'b1, "R7 low off");
        // R8: reference monitor, supply held good
        lsel = 1'b0;
        codes(20000, 0, 1'b1, 1'b0, "R8 drop");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 gate ref lockout", gate, 1'b0);
        end
        codes(20000, 3599, 1'b1, 1'b0, "R8 below on");
        codes(20000, 3600, 1'b1, 1'b1, "R8 on");
        codes(20000, 3400, 1'b1, 1'b1, "R8 at off");
        codes(20000, 3399, 1'b1, 1'b0, "R8 off");
        codes(20000, 5000, 1'b1, 1'b1, "R8 back");
        codes(0, 5000, 1'b0, 1'b1, "R8 independent");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule